// File: doc/BRIEF.md
# Request-Paced Word Copy Channel

This block is one channel of a copy engine that moves words, one at a time, between a source and a destination. Each side lives in one of up to four memory spaces, and each side's address either stays fixed or steps up by one after every word. A fixed address lets a side point at a peripheral register, such as a filter input or output buffer. The pace is set by a peripheral: a five-bit field in the control word picks one line of the request bus, and each rising request lets exactly one word through.

Software loads the working registers: source address, destination address, a count holding the number of words minus one, and the control word. Writing the control word with the enable bit set arms the channel from whatever those registers hold at that moment. At the end of the block a done flag is raised. That flag drives the interrupt line when interrupts are enabled. Depending on the transfer mode, the enable bit either clears itself or stays set. When one engine both feeds a peripheral and drains it, the draining channel must be armed before the feeding one so that no result is lost.

Top module: `reqdma_channel`

## Requirements
- R1: After reset, all four registers read zero, done and interrupt are low, and neither memory strobe is asserted.
- R2: Control bits 1:0 give the read space (mem_rspace) and bits 3:2 give the write space (mem_wspace). Code 00 is the X space and 01 is the Y space.
- R3: Control bits 6:4 set the source address mode and bits 9:7 the destination mode. The value 101 adds one to that address after each word. Any other value leaves the address unchanged.
- R4: Control bits 15:11 pick the request line (index into req_vec) that paces the channel. Activity on any other line moves no word.
- R5: A count register loaded with N-1 moves exactly N words and then stops. While words remain, the count drops by one per word.
- R6: Each word is a read cycle (mem_re) followed in the next cycle by a write cycle (mem_we) carrying the read data. The first word starts on a high selected request. Each later word needs that request to go low and then high again, so a request held high moves only one word.
- R7: Control bits 21:19 set the end behaviour. The value 101 leaves the enable bit (bit 23) set when the block ends. Any other value clears it.
- R8: done_stat rises at the end of the block and clears when the control word is written with bit 23 set. irq equals done_stat gated by control bit 22.
- R9: Writing the control word with bit 23 set re-arms the channel from the current address and count registers. Writing it with bit 23 clear halts the channel, and later requests move nothing.
- R10: prio shows control bits 18:17.
- R11: rd_data returns the register chosen by rd_sel (0 source, 1 destination, 2 count, 3 control), zero-extended to 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for writes |
| cfg_wdata | input | 24 | Register write data |
| rd_sel | input | 2 | Register select for readback |
| rd_data | output | 24 | Readback data |
| req_vec | input | NREQ | Peripheral request lines |
| mem_re | output | 1 | Read strobe |
| mem_rspace | output | 2 | Read memory space |
| mem_raddr | output | AW | Read address |
| mem_rdata | input | DW | Read data, valid the cycle after mem_re |
| mem_we | output | 1 | Write strobe |
| mem_wspace | output | 2 | Write memory space |
| mem_waddr | output | AW | Write address |
| mem_wdata | output | DW | Write data |
| done_stat | output | 1 | Block-ended status |
| irq | output | 1 | Completion interrupt |
| prio | output | 2 | Priority level |

## Verification
The assertions assume that software does not write the count or address registers while a word is in flight, and that the memory returns read data exactly one cycle after the read strobe. The bench keeps to both. It writes registers only while the channel is idle or waiting for a request, and it models a memory with one cycle of read latency. Every request pulse is followed by several idle cycles, so the read/write pair completes before the next register write or request edge.

// File: rtl/reqdma_pkg.sv
package reqdma_pkg;

  localparam int CTRL_W = 24;
  localparam int EN_BIT = 23;
  localparam int IE_BIT = 22;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  localparam logic [2:0] AMODE_STEP = 3'b101;
  localparam logic [2:0] XMODE_HOLD = 3'b101;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_WRITE
  } chan_state_e;

  function automatic logic [1:0] rd_space(input logic [CTRL_W-1:0] c);
    return c[1:0];
  endfunction

  function automatic logic [1:0] wr_space(input logic [CTRL_W-1:0] c);
    return c[3:2];
  endfunction

  function automatic logic src_steps(input logic [CTRL_W-1:0] c);
    return c[6:4] == AMODE_STEP;
  endfunction

  function automatic logic dst_steps(input logic [CTRL_W-1:0] c);
    return c[9:7] == AMODE_STEP;
  endfunction

  function automatic logic [4:0] req_index(input logic [CTRL_W-1:0] c);
    return c[15:11];
  endfunction

  function automatic logic [1:0] prio_level(input logic [CTRL_W-1:0] c);
    return c[18:17];
  endfunction

  function automatic logic holds_enable(input logic [CTRL_W-1:0] c);
    return c[21:19] == XMODE_HOLD;
  endfunction

endpackage

// File: rtl/reqdma_trigger.sv
module reqdma_trigger
  import reqdma_pkg::*;
#(
  parameter int NREQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_vec,
  input  logic [4:0]      sel_idx,
  input  logic            arm,
  input  logic            word_done,
  output logic            fire
);

  localparam int PADW = 32;

  logic [PADW-1:0] req_pad;
  logic            req_sel;
  logic            need_low;

  for (genvar i = 0; i < PADW; i++) begin : g_pad
    if (i < NREQ) begin : g_live
      assign req_pad[i] = req_vec[i];
    end else begin : g_tie
      assign req_pad[i] = 1'b0;
    end
  end

  assign req_sel = req_pad[sel_idx];
  assign fire    = req_sel & ~need_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      need_low <= 1'b0;
    end else if (arm) begin
      need_low <= 1'b0;
    end else if (word_done) begin
      need_low <= 1'b1;
    end else if (!req_sel) begin
      need_low <= 1'b0;
    end
  end

  // R6
  one_word_per_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !arm) |=> !fire);

endmodule

// File: rtl/reqdma_seq.sv
module reqdma_seq
  import reqdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic halt,
  input  logic fire,
  input  logic is_last,
  output logic rd_go,
  output logic wr_go
);

  chan_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  state_d = ST_IDLE;
      ST_WAIT:  if (fire) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = is_last ? ST_IDLE : ST_WAIT;
      default:  state_d = ST_IDLE;
    endcase
    if (arm) begin
      state_d = ST_WAIT;
    end else if (halt) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign rd_go = (state_q == ST_READ);
  assign wr_go = (state_q == ST_WRITE);

  // R6
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !arm && !halt) |=> wr_go);

  // R6
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> $past(rd_go));

endmodule

// File: rtl/reqdma_regs.sv
module reqdma_regs
  import reqdma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CNTW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              word_done,
  output logic [AW-1:0]     src_q,
  output logic [AW-1:0]     dst_q,
  output logic [CNTW-1:0]   cnt_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              done_q,
  output logic              is_last
);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic inc);
    return inc ? a + AW'(1) : a;
  endfunction

  function automatic logic [CNTW-1:0] count_down(input logic [CNTW-1:0] c);
    return c - CNTW'(1);
  endfunction

  logic wr_src, wr_dst, wr_cnt, wr_ctrl;

  assign wr_src  = cfg_we && (cfg_sel == REG_SRC);
  assign wr_dst  = cfg_we && (cfg_sel == REG_DST);
  assign wr_cnt  = cfg_we && (cfg_sel == REG_CNT);
  assign wr_ctrl = cfg_we && (cfg_sel == REG_CTRL);
  assign is_last = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (word_done) begin
        src_q <= step_addr(src_q, src_steps(ctrl_q));
        dst_q <= step_addr(dst_q, dst_steps(ctrl_q));
        if (!is_last) begin
          cnt_q <= count_down(cnt_q);
        end else begin
          done_q <= 1'b1;
          if (!holds_enable(ctrl_q)) ctrl_q[EN_BIT] <= 1'b0;
        end
      end
      if (wr_src) src_q <= cfg_wdata[AW-1:0];
      if (wr_dst) dst_q <= cfg_wdata[AW-1:0];
      if (wr_cnt) cnt_q <= cfg_wdata[CNTW-1:0];
      if (wr_ctrl) begin
        ctrl_q <= cfg_wdata;
        if (cfg_wdata[EN_BIT]) done_q <= 1'b0;
      end
    end
  end

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !is_last && !wr_cnt) |=> (cnt_q == $past(cnt_q) - CNTW'(1)));

  // R3
  src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !src_steps(ctrl_q) && !wr_src) |=> $stable(src_q));

  // R3
  dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && dst_steps(ctrl_q) && !wr_dst) |=> (dst_q == $past(dst_q) + AW'(1)));

  // R7
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && is_last && !holds_enable(ctrl_q) && !wr_ctrl) |=> !ctrl_q[EN_BIT]);

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(word_done && is_last));

endmodule

// File: rtl/reqdma_channel.sv
module reqdma_channel
  import reqdma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 24,
  parameter int CNTW = 16,
  parameter int NREQ = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic [1:0]        rd_sel,
  output logic [CTRL_W-1:0] rd_data,
  input  logic [NREQ-1:0]   req_vec,
  output logic              mem_re,
  output logic [1:0]        mem_rspace,
  output logic [AW-1:0]     mem_raddr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mem_we,
  output logic [1:0]        mem_wspace,
  output logic [AW-1:0]     mem_waddr,
  output logic [DW-1:0]     mem_wdata,
  output logic              done_stat,
  output logic              irq,
  output logic [1:0]        prio
);

  logic [AW-1:0]     src_q, dst_q;
  logic [CNTW-1:0]   cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              done_q, is_last;
  logic              arm, halt, fire, rd_go, wr_go;

  assign arm  = cfg_we && (cfg_sel == REG_CTRL) &&  cfg_wdata[EN_BIT];
  assign halt = cfg_we && (cfg_sel == REG_CTRL) && !cfg_wdata[EN_BIT];

  reqdma_regs #(.AW(AW), .CNTW(CNTW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .word_done(wr_go),
    .src_q    (src_q),
    .dst_q    (dst_q),
    .cnt_q    (cnt_q),
    .ctrl_q   (ctrl_q),
    .done_q   (done_q),
    .is_last  (is_last)
  );

  reqdma_trigger #(.NREQ(NREQ)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vec  (req_vec),
    .sel_idx  (req_index(ctrl_q)),
    .arm      (arm),
    .word_done(wr_go),
    .fire     (fire)
  );

  reqdma_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (arm),
    .halt   (halt),
    .fire   (fire),
    .is_last(is_last),
    .rd_go  (rd_go),
    .wr_go  (wr_go)
  );

  assign mem_re     = rd_go;
  assign mem_rspace = rd_space(ctrl_q);
  assign mem_raddr  = src_q;
  assign mem_we     = wr_go;
  assign mem_wspace = wr_space(ctrl_q);
  assign mem_waddr  = dst_q;
  assign mem_wdata  = mem_rdata;
  assign done_stat  = done_q;
  assign irq        = done_q & ctrl_q[IE_BIT];
  assign prio       = prio_level(ctrl_q);

  always_comb begin
    unique case (rd_sel)
      REG_SRC:  rd_data = CTRL_W'(src_q);
      REG_DST:  rd_data = CTRL_W'(dst_q);
      REG_CNT:  rd_data = CTRL_W'(cnt_q);
      default:  rd_data = ctrl_q;
    endcase
  end

endmodule

// File: tb/reqdma_channel_tb.sv
`timescale 1ns/1ps
module reqdma_channel_tb_top;
  localparam int AW = 16, DW = 24, CNTW = 16, NREQ = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_sel = '0;
  logic [23:0]     cfg_wdata = '0;
  logic [1:0]      rd_sel = '0;
  logic [23:0]     rd_data;
  logic [NREQ-1:0] req_vec = '0;
  logic            mem_re, mem_we, done_stat, irq;
  logic [1:0]      mem_rspace, mem_wspace, prio;
  logic [AW-1:0]   mem_raddr, mem_waddr;
  logic [DW-1:0]   mem_rdata = '0;
  logic [DW-1:0]   mem_wdata;

  reqdma_channel #(.AW(AW), .DW(DW), .CNTW(CNTW), .NREQ(NREQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .req_vec(req_vec),
    .mem_re(mem_re), .mem_rspace(mem_rspace), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wspace(mem_wspace), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .done_stat(done_stat), .irq(irq), .prio(prio));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory seen by the block: one cycle read latency
  logic [DW-1:0] mem [4][256];
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_rspace][mem_raddr[7:0]];
    if (mem_we) mem[mem_wspace][mem_waddr[7:0]] <= mem_wdata;
  end

  function automatic logic [DW-1:0] seed(input int sp, input int a);
    return DW'(32'h100000 + sp * 32'h10000 + a * 32'h111);
  endfunction

  // behavioural reference model
  logic [AW-1:0]   m_src, m_dst;
  logic [CNTW-1:0] m_cnt;
  logic [23:0]     m_ctrl;
  bit              m_done, m_nl;
  int              m_phase;   // 0 idle, 1 waiting, 2 reading, 3 writing
  logic [DW-1:0]   m_data;
  logic [DW-1:0]   mm [4][256];
  bit              run_cmp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = '0; m_dst = '0; m_cnt = '0; m_ctrl = '0;
      m_done = 0; m_nl = 0; m_phase = 0; m_data = '0;
    end else begin
      bit rq, old_nl;
      int ph;
      rq = req_vec[m_ctrl[15:11]];
      old_nl = m_nl;
      ph = m_phase;
      if (ph == 3) m_nl = 1;
      else if (!rq) m_nl = 0;
      if (ph == 1 && rq && !old_nl) m_phase = 2;
      if (ph == 2) begin
        m_data = mm[m_ctrl[1:0]][m_src[7:0]];
        m_phase = 3;
      end
      if (ph == 3) begin
        mm[m_ctrl[3:2]][m_dst[7:0]] = m_data;
        if (m_ctrl[6:4] == 3'b101) m_src = m_src + 1'b1;
        if (m_ctrl[9:7] == 3'b101) m_dst = m_dst + 1'b1;
        if (m_cnt != 0) begin
          m_cnt = m_cnt - 1'b1;
          m_phase = 1;
        end else begin
          m_done = 1;
          if (m_ctrl[21:19] != 3'b101) m_ctrl[23] = 1'b0;
          m_phase = 0;
        end
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_src = cfg_wdata[AW-1:0];
          2'd1: m_dst = cfg_wdata[AW-1:0];
          2'd2: m_cnt = cfg_wdata[CNTW-1:0];
          default: begin
            m_ctrl = cfg_wdata;
            if (cfg_wdata[23]) begin
              m_done = 0; m_phase = 1; m_nl = 0;
            end else begin
              m_phase = 0;
            end
          end
        endcase
      end
    end
  end

  // compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (run_cmp) begin
      logic [23:0] exp_rd;
      chk(mem_re == (m_phase == 2), "R6", "read strobe", mem_re, m_phase == 2);
      chk(mem_we == (m_phase == 3), "R6", "write strobe", mem_we, m_phase == 3);
      if (mem_re) begin
        chk(mem_raddr == m_src, "R3", "read address", mem_raddr, m_src);
        chk(mem_rspace == m_ctrl[1:0], "R2", "read space", mem_rspace, m_ctrl[1:0]);
      end
      if (mem_we) begin
        chk(mem_waddr == m_dst, "R3", "write address", mem_waddr, m_dst);
        chk(mem_wspace == m_ctrl[3:2], "R2", "write space", mem_wspace, m_ctrl[3:2]);
        chk(mem_wdata == m_data, "R6", "write data", mem_wdata, m_data);
      end
      chk(done_stat == m_done, "R8", "done", done_stat, m_done);
      chk(irq == (m_done && m_ctrl[22]), "R8", "irq", irq, m_done && m_ctrl[22]);
      chk(prio == m_ctrl[18:17], "R10", "prio", prio, m_ctrl[18:17]);
      case (rd_sel)
        2'd0: exp_rd = 24'(m_src);
        2'd1: exp_rd = 24'(m_dst);
        2'd2: exp_rd = 24'(m_cnt);
        default: exp_rd = m_ctrl;
      endcase
      chk(rd_data == exp_rd, "R11", "readback", rd_data, exp_rd);
    end
  end

  function automatic logic [23:0] mk_ctrl(input bit en, input bit ie, input logic [2:0] xm,
      input logic [1:0] pr, input logic [4:0] rq, input logic [2:0] dm, input logic [2:0] sm,
      input logic [1:0] ds, input logic [1:0] ss);
    return {en, ie, xm, pr, 1'b0, rq, 1'b0, dm, sm, ds, ss};
  endfunction

  task automatic wr(input logic [1:0] s, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    req_vec[idx] = 1'b1;
    @(negedge clk);
    req_vec[idx] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] s, output logic [23:0] v);
    @(negedge clk);
    rd_sel = s;
    #0.5;
    v = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] v;
    logic [23:0] c;
    for (int sp = 0; sp < 4; sp++)
      for (int a = 0; a < 256; a++) begin
        mem[sp][a] = seed(sp, a);
        mm[sp][a] = seed(sp, a);
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_cmp = 1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk(v == 0, "R1", "register after reset", v, 0);
    end
    chk(!irq && !done_stat && !mem_re && !mem_we, "R1", "outputs after reset",
        {irq, done_stat, mem_re, mem_we}, 0);

    // block A: X 0x10 stepping -> Y 0x40 stepping, 4 words, request 21
    wr(2'd0, 24'h10);
    wr(2'd1, 24'h40);
    wr(2'd2, 24'd3);
    c = mk_ctrl(1, 1, 3'b001, 2'd2, 5'd21, 3'b101, 3'b101, 2'b01, 2'b00);
    wr(2'd3, c);
    chk(prio == 2'd2, "R10", "prio field", prio, 2);
    pulse(22);
    rd(2'd1, v);
    chk(v == 24'h40, "R4", "unselected request moved a word", v, 24'h40);
    for (int i = 0; i < 4; i++) pulse(21);
    for (int i = 0; i < 4; i++)
      chk(mem[1][8'h40 + i] == seed(0, 16 + i), "R5", "copied word",
          mem[1][8'h40 + i], seed(0, 16 + i));
    chk(mem[1][8'h44] == seed(1, 8'h44), "R5", "word past the block", mem[1][8'h44], seed(1, 8'h44));
    rd(2'd3, v);
    chk(v[23] == 1'b0, "R7", "enable after end in clearing mode", v[23], 0);
    chk(done_stat && irq, "R8", "done and irq", {done_stat, irq}, 2'b11);
    rd(2'd0, v);
    chk(v == 24'h14, "R3", "stepped source", v, 24'h14);
    rd(2'd2, v);
    chk(v == 0, "R5", "count at end", v, 0);

    // block B: fixed Y 0x30 -> X 0x60 stepping, 2 words, hold mode, request 3
    wr(2'd0, 24'h30);
    wr(2'd1, 24'h60);
    wr(2'd2, 24'd1);
    c = mk_ctrl(1, 0, 3'b101, 2'd1, 5'd3, 3'b101, 3'b100, 2'b00, 2'b01);
    wr(2'd3, c);
    chk(!done_stat, "R8", "done cleared by arming", done_stat, 0);
    @(negedge clk);
    req_vec[3] = 1'b1;
    repeat (12) @(negedge clk);
    rd(2'd1, v);
    chk(v == 24'h61, "R6", "held request moved one word", v, 24'h61);
    req_vec[3] = 1'b0;
    repeat (3) @(negedge clk);
    pulse(3);
    chk(mem[0][8'h60] == seed(1, 8'h30) && mem[0][8'h61] == seed(1, 8'h30), "R3",
        "fixed source replicated", mem[0][8'h61], seed(1, 8'h30));
    chk(mem[0][8'h62] == seed(0, 8'h62), "R5", "word past the block", mem[0][8'h62], seed(0, 8'h62));
    rd(2'd3, v);
    chk(v[23] == 1'b1, "R7", "enable kept in hold mode", v[23], 1);
    chk(done_stat && !irq, "R8", "done without irq enable", {done_stat, irq}, 2'b10);
    rd(2'd0, v);
    chk(v == 24'h30, "R3", "fixed source address", v, 24'h30);

    // block C: re-arm from current registers, halt, resume
    wr(2'd2, 24'd2);
    c = mk_ctrl(1, 1, 3'b001, 2'd3, 5'd3, 3'b101, 3'b100, 2'b00, 2'b01);
    wr(2'd3, c);
    chk(!done_stat, "R9", "re-arm clears done", done_stat, 0);
    pulse(3);
    rd(2'd1, v);
    chk(v == 24'h63, "R9", "re-armed from current destination", v, 24'h63);
    wr(2'd3, c & ~24'h800000);
    pulse(3);
    pulse(3);
    rd(2'd1, v);
    chk(v == 24'h63, "R9", "halted channel moved a word", v, 24'h63);
    chk(mem[0][8'h63] == seed(0, 8'h63), "R9", "halted write", mem[0][8'h63], seed(0, 8'h63));
    wr(2'd3, c);
    pulse(3);
    pulse(3);
    rd(2'd1, v);
    chk(v == 24'h65, "R9", "resumed block end address", v, 24'h65);
    chk(done_stat && irq, "R8", "done after resumed block", {done_stat, irq}, 2'b11);
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule